// File: doc/BRIEF.md
# Load-Multiple Read Burst Mapper

This block turns a noncacheable load-multiple request into read address transactions. A request gives a byte start address, a word count from one to eight, and a flag for the memory type. The flag is set for strongly-ordered or device memory and clear for normal noncacheable memory or for a disabled cache. The block accepts the request in one cycle. On the next cycle it presents the first read address transaction. If the words fit inside the 32-byte line that holds the start address, one transaction covers them. If they would run past the end of that line, the block issues two transactions. The first runs from the start word up to the last word of the line. The second restarts at offset zero of the same line and fetches the words that remain.

Beat size and beat count depend on the memory type, the word count and whether the start word sits at an even or odd position. Device accesses use doubleword beats only when both the start and the count are even, so each beat carries exactly the words requested. Normal accesses use doubleword beats that cover every doubleword the words touch. The exception is a single word, which is always one 32-bit beat. The block holds each transaction until the downstream side accepts it. It reports busy and refuses new requests until the last transaction has been accepted.

Top module: `ldm_burst_mapper`

## Requirements
- R1: While reset is asserted, and in the first cycle after release, `ar_valid` and `busy` are low, and a request held during reset is not taken.
- R2: Every transaction has `ar_burst` = 2'b01 (incrementing). `ar_size` is 3'b010 for 32-bit beats and 3'b011 for 64-bit beats. `ar_len` is the beat count minus one.
- R3: For device memory (`req_dev` = 1), an operation of n words at word position w within the line uses 64-bit size and n/2 beats when n and w are both even. Otherwise it uses 32-bit size and n beats.
- R4: For normal memory (`req_dev` = 0), a one-word operation is one 32-bit beat. Any larger operation uses 64-bit size and one beat for each doubleword it touches, which is (w mod 2 + n + 1) / 2 beats.
- R5: The word position w is `req_addr[4:2]`. The word count n is `req_cnt` + 1. When w + n > 8, two operations are issued. The first has 8 − w words at the start address. The second has n − (8 − w) words at offset zero of the same line, with the same upper address bits. Each operation is mapped by R3 or R4 using its own position and count.
- R6: The second operation of a split is presented in the cycle after the first is accepted (`ar_valid` and `ar_ready` both high), and not before.
- R7: While `ar_valid` is high and `ar_ready` is low, `ar_valid`, `ar_addr`, `ar_size` and `ar_len` keep their values.
- R8: `busy` is high from the cycle after a request is accepted until the cycle after its last transaction is accepted. A request is taken only when `req_valid` is high and `busy` is low. Requests seen while busy have no effect.
- R9: `ar_addr` equals the operation's start address with bits [1:0] cleared, so bits [4:0] never exceed 0x1C. No transaction extends past the end of its 32-byte line.
- R10: The first transaction of a request appears on `ar_valid` in the cycle right after the request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | Byte start address of the load |
| req_cnt | input | 3 | Word count minus one |
| req_dev | input | 1 | 1 = strongly-ordered/device, 0 = normal noncacheable or cache off |
| busy | output | 1 | Request in progress; new requests refused |
| ar_valid | output | 1 | Read address valid |
| ar_ready | input | 1 | Read address accepted by downstream |
| ar_addr | output | ADDR_W | Transaction start address |
| ar_burst | output | 2 | Burst type, always incrementing |
| ar_size | output | 3 | Beat size code |
| ar_len | output | 8 | Beats minus one |

## Verification
The bench sweeps every start word from 0 to 7, every word count from 1 to 8, and both memory types. This sweep separates single transactions from splits, tells the even and odd start rules apart, and shows the device and normal mappings diverging on the same geometry. The acceptance stall varies from zero to two cycles, which exercises holding a transaction stable and the ordering of the second half of a split. Some runs keep a conflicting request asserted while the block is busy, to show it is ignored. Junk in the low address bits and changing upper line addresses confirm the address clearing and the wrap back to offset zero.

// File: rtl/ldm_burst_mapper.sv
module ldm_burst_mapper #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_cnt,
  input  logic              req_dev,
  output logic              busy,
  output logic              ar_valid,
  input  logic              ar_ready,
  output logic [ADDR_W-1:0] ar_addr,
  output logic [1:0]        ar_burst,
  output logic [2:0]        ar_size,
  output logic [7:0]        ar_len
);

  localparam logic [2:0] SZ32 = 3'b010;
  localparam logic [2:0] SZ64 = 3'b011;
  localparam int         LW   = ADDR_W - 5;

  function automatic logic [6:0] plan_op(input logic [2:0] w, input logic [3:0] n, input logic dev);
    logic [4:0] dws;
    dws = ({4'b0, w[0]} + {1'b0, n} + 5'd1) >> 1;
    if (dev) begin
      if (!n[0] && !w[0]) return {SZ64, n >> 1};
      return {SZ32, n};
    end
    if (n == 4'd1) return {SZ32, 4'd1};
    return {SZ64, dws[3:0]};
  endfunction

  logic [2:0]  w_in;
  logic [3:0]  n_in, room, n_first, n_rest;
  logic        split, take;
  logic [6:0]  first_op, rest_op;

  assign w_in    = req_addr[4:2];
  assign n_in    = {1'b0, req_cnt} + 4'd1;
  assign room    = 4'd8 - {1'b0, w_in};
  assign split   = n_in > room;
  assign n_first = split ? room : n_in;
  assign n_rest  = n_in - room;
  assign take    = req_valid && !ar_valid;
  assign first_op = plan_op(w_in, n_first, req_dev);

  logic              pend_q, dev_q;
  logic [LW-1:0]     base_q;
  logic [3:0]        pend_n;
  logic [2:0]        size_q;
  logic [3:0]        beats_q;
  logic [ADDR_W-1:0] addr_q;
  logic              v_q;

  assign rest_op = plan_op(3'd0, pend_n, dev_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q     <= 1'b0;
      pend_q  <= 1'b0;
      dev_q   <= 1'b0;
      base_q  <= '0;
      pend_n  <= '0;
      size_q  <= SZ32;
      beats_q <= 4'd1;
      addr_q  <= '0;
    end else if (take) begin
      v_q     <= 1'b1;
      addr_q  <= {req_addr[ADDR_W-1:2], 2'b00};
      {size_q, beats_q} <= first_op;
      pend_q  <= split;
      base_q  <= req_addr[ADDR_W-1:5];
      pend_n  <= n_rest;
      dev_q   <= req_dev;
    end else if (v_q && ar_ready) begin
      if (pend_q) begin
        addr_q <= {base_q, 5'b0};
        {size_q, beats_q} <= rest_op;
        pend_q <= 1'b0;
      end else begin
        v_q <= 1'b0;
      end
    end
  end

  logic unused_lsb;
  assign unused_lsb = ^req_addr[1:0];

  assign busy     = v_q;
  assign ar_valid = v_q;
  assign ar_addr  = addr_q;
  assign ar_burst = 2'b01;
  assign ar_size  = size_q;
  assign ar_len   = {4'b0, beats_q - 4'd1};

  // R10
  start_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ar_valid) |-> $past(req_valid && !busy));

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ar_valid && !ar_ready |=> ar_valid && $stable(ar_addr) && $stable(ar_size) && $stable(ar_len));

  // R2
  burst_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ar_valid |-> ar_burst == 2'b01 && (ar_size == SZ32 || ar_size == SZ64));

  // R9
  line_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ar_valid |-> ar_addr[1:0] == 2'b00 &&
      ((ar_size == SZ32) ?
        ({5'b0, ar_addr[4:0]} + ({2'b0, ar_len} + 10'd1) * 10'd4 <= 10'd32) :
        ({5'b0, ar_addr[4:3], 3'b0} + ({2'b0, ar_len} + 10'd1) * 10'd8 <= 10'd32)));

  // R5
  zero_offset_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ar_valid && ar_ready && ar_addr[4:0] == 5'd0 |=> !ar_valid);

endmodule

// File: tb/tb_ldm_burst_mapper.sv
module tb_ldm_burst_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [2:0]  req_cnt = '0;
  logic        req_dev = 1'b0;
  logic        ar_ready = 1'b0;
  logic        busy, ar_valid;
  logic [31:0] ar_addr;
  logic [1:0]  ar_burst;
  logic [2:0]  ar_size;
  logic [7:0]  ar_len;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ldm_burst_mapper #(.ADDR_W(32)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_cnt(req_cnt), .req_dev(req_dev), .busy(busy), .ar_valid(ar_valid),
    .ar_ready(ar_ready), .ar_addr(ar_addr), .ar_burst(ar_burst),
    .ar_size(ar_size), .ar_len(ar_len));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic exp_map(input int w, input int n, input bit dev, output int size, output int beats);
    if (dev) begin
      if (n % 2 == 0 && w % 2 == 0) begin size = 3; beats = n / 2; end
      else begin size = 2; beats = n; end
    end else if (n == 1) begin
      size = 2; beats = 1;
    end else begin
      size = 3; beats = (w % 2 + n + 1) / 2;
    end
  endtask

  task automatic check_op(input string tag, input logic [31:0] a, input int size, input int beats);
    chk({tag, " ar_valid"}, 32'(ar_valid), 32'd1);
    chk({tag, " ar_addr"}, ar_addr, a);
    chk("R2 ar_burst", 32'(ar_burst), 32'd1);
    chk({tag, " ar_size"}, 32'(ar_size), 32'(size));
    chk({tag, " ar_len"}, 32'(ar_len), 32'(beats - 1));
  endtask

  task automatic run_req(input logic [31:0] addr, input int cnt, input bit dev, input int stall, input bit hold);
    int w, n, nops, size, beats;
    logic [31:0] line, oa [2];
    int ow [2], on [2];
    w = int'(addr[4:2]);
    n = cnt + 1;
    line = {addr[31:5], 5'b0};
    if (w + n > 8) begin
      nops = 2;
      oa[0] = line + 32'(w * 4); ow[0] = w; on[0] = 8 - w;
      oa[1] = line;              ow[1] = 0; on[1] = n - (8 - w);
    end else begin
      nops = 1;
      oa[0] = line + 32'(w * 4); ow[0] = w; on[0] = n;
      oa[1] = line;              ow[1] = 0; on[1] = 0;
    end
    @(negedge clk);
    chk("R8 idle before request", 32'(busy), 32'd0);
    req_valid = 1'b1; req_addr = addr; req_cnt = 3'(cnt); req_dev = dev;
    @(posedge clk);
    @(negedge clk);
    if (hold) begin
      req_addr = ~addr; req_cnt = ~3'(cnt); req_dev = ~dev;
    end else req_valid = 1'b0;
    chk("R10 first op next cycle", 32'(ar_valid), 32'd1);
    chk("R8 busy during request", 32'(busy), 32'd1);
    for (int k = 0; k < nops; k++) begin
      string tag;
      exp_map(ow[k], on[k], dev, size, beats);
      if (k == 1) tag = "R5 second";
      else if (dev) tag = "R3";
      else tag = "R4";
      if (k == 1) chk("R6 second follows acceptance", 32'(ar_valid), 32'd1);
      check_op(tag, oa[k], size, beats);
      chk("R9 low address bits", 32'(ar_addr[1:0]), 32'd0);
      for (int s = 0; s < stall; s++) begin
        @(posedge clk);
        @(negedge clk);
        check_op("R7 hold", oa[k], size, beats);
      end
      ar_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      ar_ready = 1'b0;
    end
    chk("R8 valid drops after last", 32'(ar_valid), 32'd0);
    chk("R8 busy drops after last", 32'(busy), 32'd0);
    req_valid = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int idx;
    req_valid = 1'b1; req_addr = 32'h40; req_cnt = 3'd4;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 valid in reset", 32'(ar_valid), 32'd0);
    chk("R1 busy in reset", 32'(busy), 32'd0);
    rst_n = 1'b1;
    req_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R1 valid after release", 32'(ar_valid), 32'd0);
    chk("R1 busy after release", 32'(busy), 32'd0);
    idx = 0;
    for (int dev = 0; dev < 2; dev++)
      for (int w = 0; w < 8; w++)
        for (int cnt = 0; cnt < 8; cnt++) begin
          logic [31:0] a;
          a = 32'h1000_0000 + 32'(idx) * 32'h140 + 32'(w * 4) + 32'(idx % 4);
          run_req(a, cnt, bit'(dev), (w + cnt + dev) % 3, (idx % 5) == 0);
          idx++;
        end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule